// File: doc/BRIEF.md
# Two-Cycle Learn Command Decoder

This block is the device-side decoder for the two-cycle "learn" command that a host issues on a search-engine command bus. On each clock it samples a command-valid strobe and a 9-bit command word. A learn needs two consecutive valid cycles that both carry the learn opcode. The first cycle supplies the comparand-pair index and the two upper SRAM address bits. The second cycle supplies the table-width select, and the lower SRAM address bits are taken from a registered input in that same cycle.

When both halves are accepted, the block raises a one-cycle write request toward the data array. The request carries the pair index, a width flag and a comparand mask. The mask selects only the even comparand of the pair for a narrow table, and both comparands for a wide table. A fixed number of cycles after the second command cycle, the block pulses an active-low SRAM write strobe with the full 22-bit address. That delay matches the search-to-SRAM-read latency for the configured cascade size. The delay line keeps every learn in flight separate, so back-to-back learns each produce their own SRAM write. A malformed second cycle aborts the learn and raises a one-cycle protocol-error pulse.

Top module: `learn_decode_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `arr_wr_o` and `proto_err_o` are 0, `sram_we_n_o` is 1 and `sram_addr_o` is 0.
- R2: A learn is recognized when two consecutive cycles have `cmd_valid_i`=1 and opcode bits `cmd_i[1:0]`=2'b11, starting from idle. `arr_wr_o` is then 1 for exactly the one cycle after the second command cycle, and `arr_idx_o` equals `cmd_i[5:2]` of the first cycle.
- R3: In the second command cycle, `cmd_i[6]`=0 selects a narrow table: `arr_wide_o`=0 and `arr_cmp_mask_o`=2'b01, so only the even comparand is written. `cmd_i[6]`=1 selects a wide table: `arr_wide_o`=1 and `arr_cmp_mask_o`=2'b11. Bit 0 of the mask is 1 on every array write.
- R4: `sram_we_n_o` is 0 for exactly one cycle, L cycles after the second command cycle. L is 4, 5 or 6 for `tbl_size_i` values 2'b00, 2'b01 and 2'b10. The reserved value 2'b11 uses L=6.
- R5: While the strobe is low, `sram_addr_o[21:20]` equals `cmd_i[8:7]` of the first cycle and `sram_addr_o[19:0]` equals `sram_lo_addr_i` sampled in the second cycle. While the strobe is high, `sram_addr_o` is 0.
- R6: If `cmd_valid_i` is 0 in the cycle after a first half, the learn is aborted. `proto_err_o` is 1 for the next single cycle, and neither an array write nor an SRAM write follows.
- R7: If the cycle after a first half is valid but its opcode is not 2'b11, the learn is aborted with the same single error pulse and no writes. That cycle does not start a new learn.
- R8: A new learn may start in the cycle right after a second command cycle. Two such back-to-back learns each produce their own array write and SRAM write, in order, with their own fields.
- R9: In idle, a valid cycle whose opcode is not 2'b11, or any cycle with `cmd_valid_i`=0, produces no write and no error and does not disturb a following learn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid_i | input | 1 | Command-valid strobe |
| cmd_i | input | 9 | Command word: opcode [1:0], index [5:2], width [6], upper address [8:7] |
| tbl_size_i | input | 2 | Cascade size setting that selects the SRAM write latency |
| sram_lo_addr_i | input | 20 | Lower SRAM address bits, sampled in the second command cycle |
| arr_wr_o | output | 1 | One-cycle comparand write request to the data array |
| arr_idx_o | output | 4 | Comparand-pair index of the write |
| arr_wide_o | output | 1 | 1 for a wide-table write, 0 for a narrow one |
| arr_cmp_mask_o | output | 2 | Comparands of the pair to write (bit 0 even, bit 1 odd) |
| sram_we_n_o | output | 1 | Active-low SRAM write strobe |
| sram_addr_o | output | 22 | SRAM write address, 0 while the strobe is high |
| proto_err_o | output | 1 | One-cycle pulse on an aborted learn |

## Verification
The delay-line assertions assume that `tbl_size_i` stays constant while any learn is still waiting for its SRAM strobe. A change of latency with an entry in flight could make two entries land in the same stage. The bench therefore changes the size setting only between scenarios, after enough idle cycles to empty the line. The single-pulse checks rely on learns being at least two cycles apart, which the two-cycle protocol guarantees. All inputs are driven away from the sampling edge, so each command word is seen in exactly one cycle.

// File: rtl/learn_pkg.sv
package learn_pkg;

    // Command word layout
    localparam int CMD_W    = 9;
    localparam int OP_LSB   = 0;
    localparam int OP_W     = 2;
    localparam int IDX_LSB  = 2;
    localparam int IDX_W    = 4;
    localparam int WIDE_BIT = 6;
    localparam int HI_LSB   = 7;
    localparam int HI_W     = 2;

    // SRAM address split
    localparam int LO_W   = 20;
    localparam int ADDR_W = HI_W + LO_W;

    localparam int MASK_W = 2;

    localparam logic [OP_W-1:0] OP_LEARN = 2'b11;

    // Default latencies per cascade size
    localparam int LAT_DEF_SINGLE = 4;
    localparam int LAT_DEF_MID    = 5;
    localparam int LAT_DEF_LARGE  = 6;

    typedef enum logic [1:0] {
        TS_SINGLE = 2'b00,
        TS_UPTO8  = 2'b01,
        TS_UPTO31 = 2'b10,
        TS_RSVD   = 2'b11
    } tsize_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_HAVE_A = 1'b1
    } lrn_state_e;

    // Fields kept from the first command cycle
    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [HI_W-1:0]  hi;
    } first_half_t;

    // Decoded learn, one cycle after the second command cycle
    typedef struct packed {
        logic              vld;
        logic [IDX_W-1:0]  idx;
        logic              wide;
        logic [ADDR_W-1:0] addr;
    } learn_req_t;

    // One delay-line stage
    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
    } sram_slot_t;

    function automatic logic is_learn_op(input logic [CMD_W-1:0] c);
        return c[OP_LSB +: OP_W] == OP_LEARN;
    endfunction

    function automatic first_half_t take_first(input logic [CMD_W-1:0] c);
        first_half_t f;
        f.idx = c[IDX_LSB +: IDX_W];
        f.hi  = c[HI_LSB +: HI_W];
        return f;
    endfunction

    function automatic logic [MASK_W-1:0] cmp_mask(input logic wide);
        return wide ? 2'b11 : 2'b01;
    endfunction

    function automatic int pick_lat(input tsize_e ts, input int l0, input int l1, input int l2);
        case (ts)
            TS_SINGLE: return l0;
            TS_UPTO8:  return l1;
            default:   return l2;
        endcase
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/learn_fsm.sv
module learn_fsm
    import learn_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_valid_i,
    input  logic [CMD_W-1:0]     cmd_i,
    input  logic [LO_W-1:0]      lo_addr_i,
    output learn_req_t           req_o,
    output logic                 err_o
);

    lrn_state_e  state_q;
    first_half_t held_q;
    learn_req_t  req_q;
    logic        err_q;
    logic        hit;

    assign hit = cmd_valid_i && is_learn_op(cmd_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            held_q  <= '0;
            req_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            req_q.vld <= 1'b0;
            err_q     <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (hit) begin
                        held_q  <= take_first(cmd_i);
                        state_q <= ST_HAVE_A;
                    end
                end
                ST_HAVE_A: begin
                    state_q <= ST_IDLE;
                    if (hit) begin
                        req_q.vld  <= 1'b1;
                        req_q.idx  <= held_q.idx;
                        req_q.wide <= cmd_i[WIDE_BIT];
                        req_q.addr <= {held_q.hi, lo_addr_i};
                    end else begin
                        err_q <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_o = req_q;
    assign err_o = err_q;

    AST_REQ_NEEDS_OP: assert property (@(posedge clk) disable iff (rst)
        req_q.vld |-> $past(hit)) else $error("learn without opcode"); // R2
    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        req_q.vld |=> !req_q.vld) else $error("array request too long"); // R2
    AST_ERR_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        err_q |-> !req_q.vld) else $error("error with write"); // R6
    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        err_q |=> !err_q) else $error("error pulse too long"); // R7
    AST_SECOND_HALF_ENDS: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HAVE_A) |=> (state_q == ST_IDLE)) else $error("stuck in second half"); // R8

endmodule

// File: rtl/learn_lat_sel.sv
module learn_lat_sel
    import learn_pkg::*;
#(
    parameter int LAT_SINGLE = LAT_DEF_SINGLE,
    parameter int LAT_MID    = LAT_DEF_MID,
    parameter int LAT_LARGE  = LAT_DEF_LARGE,
    parameter int NST        = LAT_DEF_LARGE - 1
) (
    input  logic [1:0]     tbl_size_i,
    output logic [NST-1:0] slot_oh_o
);

    int lat;
    int tgt;

    // The request is already one register past the second command cycle,
    // so a latency of L enters stage NST+1-L.
    always_comb begin
        lat = pick_lat(tsize_e'(tbl_size_i), LAT_SINGLE, LAT_MID, LAT_LARGE);
        tgt = NST + 1 - lat;
    end

    for (genvar k = 0; k < NST; k++) begin : g_slot
        assign slot_oh_o[k] = (tgt == k);
    end

endmodule

// File: rtl/learn_sram_pipe.sv
module learn_sram_pipe
    import learn_pkg::*;
#(
    parameter int NST = LAT_DEF_LARGE - 1
) (
    input  logic           clk,
    input  logic           rst,
    input  sram_slot_t     ins_i,
    input  logic [NST-1:0] slot_oh_i,
    output sram_slot_t     out_o
);

    sram_slot_t     st_q [NST];
    logic [NST-1:0] vld_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NST; k++) begin
                st_q[k] <= '0;
            end
        end else begin
            if (ins_i.vld && slot_oh_i[0]) begin
                st_q[0] <= ins_i;
            end else begin
                st_q[0] <= '0;
            end
            for (int k = 1; k < NST; k++) begin
                if (ins_i.vld && slot_oh_i[k]) begin
                    st_q[k] <= ins_i;
                end else begin
                    st_q[k] <= st_q[k-1];
                end
            end
        end
    end

    for (genvar k = 0; k < NST; k++) begin : g_vld
        assign vld_vec[k] = st_q[k].vld;
    end

    assign out_o = st_q[NST-1];

    AST_SLOT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        ins_i.vld |-> ($countones(slot_oh_i) == 1)) else $error("bad latency slot"); // R4
    AST_NO_SLOT_CLASH: assert property (@(posedge clk) disable iff (rst)
        ins_i.vld |-> ((slot_oh_i[NST-1:1] & vld_vec[NST-2:0]) == '0)) else $error("entry overwritten"); // R8
    AST_OUT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        out_o.vld |=> !out_o.vld) else $error("adjacent strobes"); // R4

endmodule

// File: rtl/learn_decode_top.sv
module learn_decode_top
    import learn_pkg::*;
#(
    parameter int LAT_SINGLE = LAT_DEF_SINGLE,
    parameter int LAT_MID    = LAT_DEF_MID,
    parameter int LAT_LARGE  = LAT_DEF_LARGE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid_i,
    input  logic [CMD_W-1:0]  cmd_i,
    input  logic [1:0]        tbl_size_i,
    input  logic [LO_W-1:0]   sram_lo_addr_i,
    output logic              arr_wr_o,
    output logic [IDX_W-1:0]  arr_idx_o,
    output logic              arr_wide_o,
    output logic [MASK_W-1:0] arr_cmp_mask_o,
    output logic              sram_we_n_o,
    output logic [ADDR_W-1:0] sram_addr_o,
    output logic              proto_err_o
);

    localparam int MAX_LAT = max3(LAT_SINGLE, LAT_MID, LAT_LARGE);
    localparam int NST     = MAX_LAT - 1;

    learn_req_t     req;
    logic           err;
    logic [NST-1:0] slot_oh;
    sram_slot_t     ins;
    sram_slot_t     outs;

    learn_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .cmd_valid_i (cmd_valid_i),
        .cmd_i       (cmd_i),
        .lo_addr_i   (sram_lo_addr_i),
        .req_o       (req),
        .err_o       (err)
    );

    learn_lat_sel #(
        .LAT_SINGLE (LAT_SINGLE),
        .LAT_MID    (LAT_MID),
        .LAT_LARGE  (LAT_LARGE),
        .NST        (NST)
    ) u_lat (
        .tbl_size_i (tbl_size_i),
        .slot_oh_o  (slot_oh)
    );

    assign ins.vld  = req.vld;
    assign ins.addr = req.addr;

    learn_sram_pipe #(
        .NST (NST)
    ) u_pipe (
        .clk       (clk),
        .rst       (rst),
        .ins_i     (ins),
        .slot_oh_i (slot_oh),
        .out_o     (outs)
    );

    assign arr_wr_o       = req.vld;
    assign arr_idx_o      = req.idx;
    assign arr_wide_o     = req.wide;
    assign arr_cmp_mask_o = cmp_mask(req.wide);
    assign proto_err_o    = err;
    assign sram_we_n_o    = ~outs.vld;
    assign sram_addr_o    = outs.vld ? outs.addr : '0;

    AST_EVEN_ALWAYS: assert property (@(posedge clk) disable iff (rst)
        arr_wr_o |-> arr_cmp_mask_o[0]) else $error("even comparand skipped"); // R3
    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n_o |=> sram_we_n_o) else $error("strobe longer than one cycle"); // R4
    AST_ERR_VS_ARRAY: assert property (@(posedge clk) disable iff (rst)
        proto_err_o |-> !arr_wr_o) else $error("error and array write together"); // R7

endmodule

// File: tb/test_learn_decode_top.sv
module test_learn_decode_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [8:0]  cmd = '0;
    logic [1:0]  tbl_size = 2'b00;
    logic [19:0] lo_addr = '0;

    logic        arr_wr;
    logic [3:0]  arr_idx;
    logic        arr_wide;
    logic [1:0]  arr_mask;
    logic        sram_we_n;
    logic [21:0] sram_addr;
    logic        proto_err;

    int n_checks = 0;
    int n_fails  = 0;
    int tnow     = 0;
    bit done     = 1'b0;

    // Expected events, indexed by cycle number modulo 32
    logic        e_arr  [32];
    logic [3:0]  e_idx  [32];
    logic        e_wide [32];
    logic        e_strb [32];
    logic [21:0] e_addr [32];
    logic        e_err  [32];

    always #10 clk = ~clk;

    learn_decode_top i_learn_decode_top (
        .clk            (clk),
        .rst            (rst),
        .cmd_valid_i    (cmd_valid),
        .cmd_i          (cmd),
        .tbl_size_i     (tbl_size),
        .sram_lo_addr_i (lo_addr),
        .arr_wr_o       (arr_wr),
        .arr_idx_o      (arr_idx),
        .arr_wide_o     (arr_wide),
        .arr_cmp_mask_o (arr_mask),
        .sram_we_n_o    (sram_we_n),
        .sram_addr_o    (sram_addr),
        .proto_err_o    (proto_err)
    );

    task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, tnow, act, exp);
        end
    endtask

    task automatic clear_expect();
        for (int i = 0; i < 32; i++) begin
            e_arr[i] = 1'b0; e_idx[i] = '0; e_wide[i] = 1'b0;
            e_strb[i] = 1'b0; e_addr[i] = '0; e_err[i] = 1'b0;
        end
    endtask

    task automatic check_slot();
        int s;
        s = tnow % 32;
        cmp("R2 array write", 32'(arr_wr), 32'(e_arr[s]));
        if (e_arr[s]) begin
            cmp("R2 index", 32'(arr_idx), 32'(e_idx[s]));
            cmp("R3 width flag", 32'(arr_wide), 32'(e_wide[s]));
            cmp("R3 comparand mask", 32'(arr_mask), e_wide[s] ? 32'd3 : 32'd1);
        end
        cmp("R4 strobe", 32'(sram_we_n), 32'(!e_strb[s]));
        cmp("R5 address", 32'(sram_addr), e_strb[s] ? 32'(e_addr[s]) : 32'd0);
        cmp("R6_R7 error pulse", 32'(proto_err), 32'(e_err[s]));
        e_arr[s] = 1'b0; e_strb[s] = 1'b0; e_err[s] = 1'b0;
    endtask

    // Sample outputs of the current cycle, then drive the next command
    task automatic tick(input logic v, input logic [8:0] c, input logic [19:0] lo);
        @(negedge clk);
        check_slot();
        cmd_valid = v;
        cmd       = c;
        lo_addr   = lo;
        tnow++;
    endtask

    function automatic int lat_of(input logic [1:0] ts);
        case (ts)
            2'b00:   return 4;
            2'b01:   return 5;
            default: return 6;
        endcase
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(1'b0, 9'h000, 20'h0);
    endtask

    // Drives both halves and books the expected writes
    task automatic learn(input logic [3:0] idx, input logic wide, input logic [1:0] hi, input logic [19:0] lo);
        int base;
        tick(1'b1, {hi, 1'b0, idx, 2'b11}, 20'h0);
        tick(1'b1, {2'b00, wide, idx, 2'b11}, lo);
        base = tnow - 1;
        e_arr[(base + 1) % 32]  = 1'b1;
        e_idx[(base + 1) % 32]  = idx;
        e_wide[(base + 1) % 32] = wide;
        e_strb[(base + lat_of(tbl_size)) % 32] = 1'b1;
        e_addr[(base + lat_of(tbl_size)) % 32] = {hi, lo};
    endtask

    // R1: outputs during and right after reset
    task automatic sc_reset();
        @(negedge clk);
        cmp("R1 reset array write", 32'(arr_wr), 32'd0);
        cmp("R1 reset strobe", 32'(sram_we_n), 32'd1);
        cmp("R1 reset address", 32'(sram_addr), 32'd0);
        cmp("R1 reset error", 32'(proto_err), 32'd0);
        rst = 1'b0;
        idle(2);
    endtask

    // R2 R3 R4 R5: one learn under each size setting, both widths
    task automatic sc_sizes();
        for (int ts = 0; ts < 4; ts++) begin
            tbl_size = 2'(ts);
            learn(4'(ts * 3 + 1), 1'b0, 2'(ts), 20'hA5000 + 20'(ts));
            idle(8);
            learn(4'(15 - ts), 1'b1, 2'(3 - ts), 20'h0F0F0 ^ 20'(ts));
            idle(8);
        end
    endtask

    // R6: valid drops after the first half
    task automatic sc_abort_valid();
        tbl_size = 2'b01;
        tick(1'b1, {2'b11, 1'b0, 4'h9, 2'b11}, 20'h0);
        tick(1'b0, 9'h1FF, 20'hFFFFF);
        e_err[tnow % 32] = 1'b1;
        idle(8);
    endtask

    // R7: bad opcode in the second half, which is not taken as a new start
    task automatic sc_abort_op();
        tbl_size = 2'b10;
        tick(1'b1, {2'b10, 1'b1, 4'h6, 2'b11}, 20'h0);
        tick(1'b1, {2'b00, 1'b1, 4'h6, 2'b10}, 20'h12345);
        e_err[tnow % 32] = 1'b1;
        tick(1'b1, {2'b01, 1'b0, 4'h2, 2'b11}, 20'h0);
        tick(1'b0, 9'h0, 20'h0);
        e_err[tnow % 32] = 1'b1;
        idle(8);
    endtask

    // R8: back-to-back learns keep their own fields
    task automatic sc_back2back();
        tbl_size = 2'b01;
        learn(4'h3, 1'b0, 2'b01, 20'h11111);
        learn(4'hC, 1'b1, 2'b10, 20'h22222);
        learn(4'h7, 1'b1, 2'b11, 20'h33333);
        idle(10);
    endtask

    // R9: non-learn opcodes and idle cycles are ignored
    task automatic sc_ignore();
        tbl_size = 2'b00;
        tick(1'b1, {2'b11, 1'b1, 4'hF, 2'b00}, 20'h1);
        tick(1'b1, {2'b11, 1'b1, 4'hF, 2'b01}, 20'h2);
        tick(1'b1, {2'b11, 1'b1, 4'hF, 2'b10}, 20'h3);
        tick(1'b0, {2'b11, 1'b1, 4'hF, 2'b11}, 20'h4);
        tick(1'b1, {2'b00, 1'b0, 4'h0, 2'b01}, 20'h5);
        learn(4'h5, 1'b1, 2'b01, 20'h54321);
        idle(8);
    endtask

    initial begin
        clear_expect();
        repeat (3) @(posedge clk);
        sc_reset();
        sc_sizes();
        sc_abort_valid();
        sc_abort_op();
        sc_back2back();
        sc_ignore();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL R2 watchdog expired: actual 0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule